// File: doc/BRIEF.md
# Power Sequence Script Engine

This block is a scripted power sequencer. A small byte memory holds instructions. Each instruction is four bytes: a 16-bit power-bus message, a delay and the index of the next instruction. When a system event fires, the engine walks the chain of instructions that starts at that event's start pointer. For each instruction it offers the message on a valid/ready port. After the message is accepted it waits the programmed number of slow-clock ticks and then jumps to the next instruction. The index at the top of the index range (0x3f with the default width) acts as the terminator.

Software uses a byte-wide register port. It loads the memory through an address register and a data register. It sets one start pointer for each of the sleep, group-1/2 wake, group-3 wake and warm-reset events. It programs three group event registers. The pointers and the group registers accept writes only after a two-value unlock key. Events that arrive while a script runs are held pending. They are served by fixed priority once the engine returns to idle.

The sequencer FSM has four states. IDLE starts a script when an event is pending and moves to CHECK. In CHECK, the terminator returns to IDLE, an out-of-range index raises the error and returns to IDLE, and any other index moves to EMIT. EMIT holds the message until it is accepted and then moves to WAIT. WAIT counts ticks and, when the count reaches zero, loads the next index and moves to CHECK. The key FSM has three states. LOCKED moves to HALF on the first key. HALF moves to OPEN on the second key, and any other write to the key register sends it back to LOCKED. OPEN moves to HALF on the first key and to LOCKED on any other key write, including zero.

Top module: `pwr_seq_engine`

Register offsets on `reg_addr`:
- 0: key
- 1: memory byte address
- 2: memory byte data
- 4: sleep pointer
- 5: group-1/2 wake pointer
- 6: group-3 wake pointer
- 7: warm-reset pointer
- 8, 9, 10: group 1, 2 and 3 event registers

## Requirements
- R1: A write to offset 2 stores the data byte at the memory byte address last written to offset 1, and this works whether locked or not. Instruction i uses bytes 4i (message high byte), 4i+1 (message low byte), 4i+2 (delay) and 4i+3 (next index).
- R2: Writes to the pointers and the group registers take effect only after key 0xC0 and then key 0x0C have been written to offset 0 with no other key write between them. Writing 0 to offset 0 locks the registers again. Writes made while locked are ignored.
- R3: The start pointer of an event and the next field of an instruction end the script when they hold 0x3f. In that case no further message is sent and no error is raised.
- R4: Each instruction puts its message on msg_data with msg_valid high. Both hold steady until msg_ready is high.
- R5: After a message is accepted, the next step waits for exactly the delay count of slow_tick pulses. A delay of zero goes on without a tick, and the next message is accepted three cycles after the previous one.
- R6: Execution follows the next field, so the order of the instructions is independent of their position in memory.
- R7: Events that arrive during a script are kept pending. When the engine is idle they are served in this order: warm reset, power-off, group-1/2 wake, group-3 wake, sleep.
- R8: Requests are gated as follows. warm_req counts only when bit 4 of the group-1 register is set. wake12_req counts only when bit 3 of the group-1 or the group-2 register is set. wake3_req counts only when bit 3 of the group-3 register is set.
- R9: Writing the group-1 register with bit 0 set, while unlocked, raises one power-off request. A power-off request runs the script at the sleep pointer.
- R10: A start or next index above 0x3f stops the engine and sets seq_err without sending a message. seq_err clears when the next script starts.
- R11: After reset: no message is offered, busy and seq_err are low, all pointers hold 0x3f, the registers are locked and all gates are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| sleep_req | input | 1 | Active-to-sleep event |
| wake12_req | input | 1 | Sleep-to-active event for groups 1 and 2 |
| wake3_req | input | 1 | Sleep-to-active event for group 3 |
| warm_req | input | 1 | Warm-reset event |
| msg_valid | output | 1 | Message offered |
| msg_data | output | 16 | Power-bus message |
| msg_ready | input | 1 | Message accepted by the receiver |
| busy | output | 1 | A script is in progress |
| seq_err | output | 1 | The last script stopped on a bad index |

## Verification
The bench builds the block with the default 6-bit index, which gives a 256-byte memory and the terminator 0x3f. Pointer and next bytes are a full 8 bits wide, so indices from 0x40 to 0xff can be stored, and the bench uses them to reach the error stop both at the start and in mid-chain. For the chain test the bench switches the slow tick to manual pulses. This lets it show that the engine does not advance before the last counted tick and that a zero delay takes exactly three cycles.

// File: rtl/pse_pkg.sv
package pse_pkg;
    localparam int BYTE_W = 8;
    localparam int MSG_W  = 16;
    localparam int RA_W   = 4;

    // register offsets
    localparam logic [RA_W-1:0] REG_KEY      = 4'd0;
    localparam logic [RA_W-1:0] REG_MADDR    = 4'd1;
    localparam logic [RA_W-1:0] REG_MDATA    = 4'd2;
    localparam int              REG_PTR_BASE = 4;
    localparam int              REG_GRP_BASE = 8;

    // group register bit positions
    localparam int BIT_DEVOFF = 0;
    localparam int BIT_LVLWK  = 3;
    localparam int BIT_WARMEN = 4;

    // event slots, lower index wins
    localparam int EV_WARM   = 0;
    localparam int EV_OFF    = 1;
    localparam int EV_WAKE12 = 2;
    localparam int EV_WAKE3  = 3;
    localparam int EV_SLEEP  = 4;
    localparam int NUM_EVT   = 5;

    // pointer slots
    localparam int P_SLEEP  = 0;
    localparam int P_WAKE12 = 1;
    localparam int P_WAKE3  = 2;
    localparam int P_WARM   = 3;
    localparam int NUM_PTR  = 4;
    localparam int NUM_GRP  = 3;

    typedef enum logic [1:0] {S_IDLE, S_CHECK, S_EMIT, S_WAIT} core_st_e;
    typedef enum logic [1:0] {K_LOCKED, K_HALF, K_OPEN} key_st_e;
endpackage

// File: rtl/pse_key_lock.sv
module pse_key_lock
    import pse_pkg::*;
#(
    parameter logic [BYTE_W-1:0] KEY_A = 8'hC0,
    parameter logic [BYTE_W-1:0] KEY_B = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic [BYTE_W-1:0] key_data,
    output logic              unlocked
);
    key_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= K_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (key_we) begin
            unique case (st_q)
                K_LOCKED: st_d = (key_data == KEY_A) ? K_HALF : K_LOCKED;
                K_HALF:   st_d = (key_data == KEY_B) ? K_OPEN : K_LOCKED;
                K_OPEN:   st_d = (key_data == KEY_A) ? K_HALF : K_LOCKED;
                default:  st_d = K_LOCKED;
            endcase
        end
    end

    always_comb unlocked = (st_q == K_OPEN);

    AST_UNLOCK_AFTER_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_we && key_data == KEY_B)); // R2
endmodule

// File: rtl/pse_evt_arb.sv
module pse_evt_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic         any,
    output logic [N-1:0] grant_oh
);
    logic [N-1:0] pend_q;
    logic [N-1:0] higher;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(take ? grant_oh : '0)) | req;
    end

    // higher[i]: some slot of better rank is pending
    assign higher[0] = 1'b0;
    for (genvar i = 1; i < N; i++) begin : g_rank
        assign higher[i] = higher[i-1] | pend_q[i-1];
    end

    always_comb begin
        grant_oh = pend_q & ~higher;
        any      = |pend_q;
    end

    AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (any && !take) |=> any); // R7
endmodule

// File: rtl/pse_core.sv
module pse_core
    import pse_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] start_ptr,
    input  logic [MSG_W-1:0]  ins_msg,
    input  logic [BYTE_W-1:0] ins_dly,
    input  logic [BYTE_W-1:0] ins_next,
    input  logic              tick,
    input  logic              msg_ready,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              msg_valid,
    output logic [MSG_W-1:0]  msg_data,
    output logic              busy,
    output logic              seq_err
);
    localparam logic [BYTE_W-1:0] END_PTR = BYTE_W'((1 << IDX_W) - 1);

    core_st_e          st_q, st_d;
    logic [BYTE_W-1:0] cur_q, nxt_q, cnt_q;
    logic              err_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (start) st_d = S_CHECK;
            S_CHECK: st_d = (cur_q >= END_PTR) ? S_IDLE : S_EMIT;
            S_EMIT:  if (msg_ready) st_d = S_WAIT;
            S_WAIT:  if (cnt_q == '0) st_d = S_CHECK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cur_q <= END_PTR;
            nxt_q <= END_PTR;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                S_IDLE: if (start) begin
                    cur_q <= start_ptr;
                    err_q <= 1'b0;
                end
                S_CHECK: if (cur_q > END_PTR) err_q <= 1'b1;
                S_EMIT: if (msg_ready) begin
                    cnt_q <= ins_dly;
                    nxt_q <= ins_next;
                end
                S_WAIT: begin
                    if (cnt_q == '0) cur_q <= nxt_q;
                    else if (tick)   cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        cur_idx   = cur_q[IDX_W-1:0];
        msg_valid = (st_q == S_EMIT);
        msg_data  = ins_msg;
        busy      = (st_q != S_IDLE);
        seq_err   = err_q;
    end

    AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data))); // R4
    AST_DELAY_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WAIT && cnt_q != '0) |=> !msg_valid); // R5
    AST_TERM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CHECK && cur_q == END_PTR) |=> (!msg_valid && !seq_err)); // R3
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> !busy); // R10
endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
    import pse_pkg::*;
#(
    parameter int                IDX_W = 6,
    parameter logic [BYTE_W-1:0] KEY_A = 8'hC0,
    parameter logic [BYTE_W-1:0] KEY_B = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              slow_tick,
    input  logic              sleep_req,
    input  logic              wake12_req,
    input  logic              wake3_req,
    input  logic              warm_req,
    output logic              msg_valid,
    output logic [MSG_W-1:0]  msg_data,
    input  logic              msg_ready,
    output logic              busy,
    output logic              seq_err
);
    localparam int                MA_W      = IDX_W + 2;
    localparam int                MEM_BYTES = 1 << MA_W;
    localparam logic [BYTE_W-1:0] END_PTR   = BYTE_W'((1 << IDX_W) - 1);

    logic              unlocked;
    logic [BYTE_W-1:0] mem [MEM_BYTES];
    logic [MA_W-1:0]   maddr_q;
    logic [BYTE_W-1:0] ptr_q [NUM_PTR];
    logic [NUM_GRP-1:0] lvl_q;
    logic              warm_en_q;
    logic [NUM_EVT-1:0] req, grant_oh;
    logic              any, start;
    logic [BYTE_W-1:0] sel_ptr;
    logic [IDX_W-1:0]  cur_idx;
    logic [MA_W-1:0]   base;
    logic [MSG_W-1:0]  ins_msg;
    logic [BYTE_W-1:0] ins_dly, ins_next;
    logic              off_req;

    pse_key_lock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
        .clk(clk), .rst_n(rst_n),
        .key_we(reg_we && reg_addr == REG_KEY),
        .key_data(reg_wdata), .unlocked(unlocked)
    );

    // script memory, writable at any time
    always_ff @(posedge clk) begin
        if (reg_we && reg_addr == REG_MDATA) mem[maddr_q] <= reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) maddr_q <= '0;
        else if (reg_we && reg_addr == REG_MADDR) maddr_q <= reg_wdata[MA_W-1:0];
    end

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ptr_q[i] <= END_PTR;
            else if (reg_we && unlocked && reg_addr == RA_W'(REG_PTR_BASE + i))
                ptr_q[i] <= reg_wdata;
        end
        AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            !unlocked |=> $stable(ptr_q[i])); // R2
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q[g] <= 1'b0;
            else if (reg_we && unlocked && reg_addr == RA_W'(REG_GRP_BASE + g))
                lvl_q[g] <= reg_wdata[BIT_LVLWK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_en_q <= 1'b0;
        else if (reg_we && unlocked && reg_addr == RA_W'(REG_GRP_BASE))
            warm_en_q <= reg_wdata[BIT_WARMEN];
    end

    always_comb begin
        off_req           = reg_we && unlocked && reg_addr == RA_W'(REG_GRP_BASE)
                            && reg_wdata[BIT_DEVOFF];
        req               = '0;
        req[EV_WARM]      = warm_req && warm_en_q;
        req[EV_OFF]       = off_req;
        req[EV_WAKE12]    = wake12_req && (lvl_q[0] || lvl_q[1]);
        req[EV_WAKE3]     = wake3_req && lvl_q[2];
        req[EV_SLEEP]     = sleep_req;
    end

    pse_evt_arb #(.N(NUM_EVT)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .take(start),
        .any(any), .grant_oh(grant_oh)
    );

    always_comb begin
        start   = any && !busy;
        sel_ptr = '0;
        if (grant_oh[EV_WARM])   sel_ptr = sel_ptr | ptr_q[P_WARM];
        if (grant_oh[EV_OFF])    sel_ptr = sel_ptr | ptr_q[P_SLEEP];
        if (grant_oh[EV_WAKE12]) sel_ptr = sel_ptr | ptr_q[P_WAKE12];
        if (grant_oh[EV_WAKE3])  sel_ptr = sel_ptr | ptr_q[P_WAKE3];
        if (grant_oh[EV_SLEEP])  sel_ptr = sel_ptr | ptr_q[P_SLEEP];
    end

    always_comb begin
        base     = {cur_idx, 2'b00};
        ins_msg  = {mem[base], mem[base | MA_W'(1)]};
        ins_dly  = mem[base | MA_W'(2)];
        ins_next = mem[base | MA_W'(3)];
    end

    pse_core #(.IDX_W(IDX_W)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(sel_ptr),
        .ins_msg(ins_msg), .ins_dly(ins_dly), .ins_next(ins_next),
        .tick(slow_tick), .msg_ready(msg_ready), .cur_idx(cur_idx),
        .msg_valid(msg_valid), .msg_data(msg_data), .busy(busy),
        .seq_err(seq_err)
    );
endmodule

// File: tb/tb_pwr_seq_engine.sv
module tb_pwr_seq_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       slow_tick = 1'b0;
    logic       sleep_req = 1'b0, wake12_req = 1'b0, wake3_req = 1'b0, warm_req = 1'b0;
    logic       msg_valid, busy, seq_err;
    logic [15:0] msg_data;
    logic       msg_ready = 1'b1;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit tick_auto = 1;
    int divc = 0;
    int tcnt = 0;
    int cyc = 0;
    int log_n = 0;
    logic [15:0] log_msg [64];
    int log_tk [64];
    int log_cy [64];

    pwr_seq_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .slow_tick(slow_tick), .sleep_req(sleep_req),
        .wake12_req(wake12_req), .wake3_req(wake3_req), .warm_req(warm_req),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_ready(msg_ready),
        .busy(busy), .seq_err(seq_err)
    );

    always #10 clk = ~clk;

    // automatic slow tick: one pulse every 16 cycles
    initial forever begin
        @(posedge clk); #2;
        if (tick_auto) begin
            divc = (divc + 1) % 16;
            slow_tick = (divc == 0);
        end
    end

    // monitor, sampled mid-cycle
    always @(negedge clk) begin
        cyc++;
        if (slow_tick) tcnt++;
        if (msg_valid && msg_ready && log_n < 64) begin
            log_msg[log_n] = msg_data;
            log_tk[log_n]  = tcnt;
            log_cy[log_n]  = cyc;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        step(1);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic load_ins(input int idx, input logic [15:0] m, input logic [7:0] dly,
                            input logic [7:0] nxt);
        wr(4'd1, 8'(idx * 4));     wr(4'd2, m[15:8]);
        wr(4'd1, 8'(idx * 4 + 1)); wr(4'd2, m[7:0]);
        wr(4'd1, 8'(idx * 4 + 2)); wr(4'd2, dly);
        wr(4'd1, 8'(idx * 4 + 3)); wr(4'd2, nxt);
    endtask

    task automatic pulse(input int which);
        step(1);
        case (which)
            0: warm_req = 1'b1;
            2: wake12_req = 1'b1;
            3: wake3_req = 1'b1;
            default: sleep_req = 1'b1;
        endcase
        step(1);
        warm_req = 1'b0; wake12_req = 1'b0; wake3_req = 1'b0; sleep_req = 1'b0;
    endtask

    task automatic tick_once();
        step(1); slow_tick = 1'b1;
        step(1); slow_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk(msg_valid === 1'b0, "R11 valid", msg_valid, 0);
        chk(busy === 1'b0, "R11 busy", busy, 0);
        chk(seq_err === 1'b0, "R11 err", seq_err, 0);
        pulse(4); step(60);    // sleep pointer holds 0x3f
        chk(log_n == 0, "R11 ptr end", log_n, 0);
    endtask

    task automatic t_lock();
        load_ins(0, 16'hA000, 8'd2, 8'h3f);   // R1 while locked
        wr(4'd4, 8'h00);
        pulse(4); step(60);
        chk(log_n == 0, "R2 locked write", log_n, 0);
        wr(4'd0, 8'hC0); wr(4'd0, 8'h55); wr(4'd0, 8'h0C);
        wr(4'd4, 8'h00);
        pulse(4); step(60);
        chk(log_n == 0, "R2 broken key", log_n, 0);
        wr(4'd0, 8'hC0); wr(4'd0, 8'h0C);
        wr(4'd4, 8'h00);
        pulse(4); step(60);
        chk(log_n == 1, "R2 unlocked count", log_n, 1);
        chk(log_msg[0] == 16'hA000, "R1 message bytes", log_msg[0], 16'hA000);
    endtask

    task automatic t_prio();
        load_ins(1, 16'hB100, 8'd2, 8'h3f);
        load_ins(2, 16'hB300, 8'd2, 8'h3f);
        load_ins(3, 16'hC000, 8'd2, 8'h3f);
        wr(4'd5, 8'd1); wr(4'd6, 8'd2); wr(4'd7, 8'd3);
        wr(4'd8, 8'h18); wr(4'd10, 8'h08);
        step(20);
        log_n = 0;
        pulse(4); step(4);
        pulse(4); pulse(3); pulse(2);
        wr(4'd8, 8'h19);        // power-off request
        pulse(0);
        step(500);
        chk(log_n == 6, "R7 count", log_n, 6);
        chk(log_msg[0] == 16'hA000, "R7 first", log_msg[0], 16'hA000);
        chk(log_msg[1] == 16'hC000, "R7 warm first", log_msg[1], 16'hC000);
        chk(log_msg[2] == 16'hA000, "R9 off uses sleep ptr", log_msg[2], 16'hA000);
        chk(log_msg[3] == 16'hB100, "R7 wake12", log_msg[3], 16'hB100);
        chk(log_msg[4] == 16'hB300, "R7 wake3", log_msg[4], 16'hB300);
        chk(log_msg[5] == 16'hA000, "R7 sleep last", log_msg[5], 16'hA000);
        chk(log_tk[2] - log_tk[1] == 2, "R5 delay two", log_tk[2] - log_tk[1], 2);
    endtask

    task automatic t_gate();
        wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00);
        step(5); log_n = 0;
        pulse(0); pulse(2); pulse(3);
        step(80);
        chk(log_n == 0, "R8 gates closed", log_n, 0);
        wr(4'd9, 8'h08);
        pulse(2); step(60);
        chk(log_n == 1 && log_msg[0] == 16'hB100, "R8 group2 wake", log_msg[0], 16'hB100);
        wr(4'd10, 8'h08); step(40);
    endtask

    task automatic t_chain();
        load_ins(5, 16'h1005, 8'd1, 8'd9);
        load_ins(9, 16'h1009, 8'd0, 8'd7);
        load_ins(7, 16'h1007, 8'd3, 8'h3f);
        wr(4'd6, 8'd5);
        step(40);
        tick_auto = 0; slow_tick = 1'b0;
        log_n = 0;
        pulse(3);
        for (int i = 0; i < 50 && log_n < 1; i++) step(1);
        step(10);
        chk(log_n == 1, "R5 holds without tick", log_n, 1);
        tick_once(); step(12);
        chk(log_n == 3, "R6 chain count", log_n, 3);
        chk(log_msg[0] == 16'h1005 && log_msg[1] == 16'h1009 && log_msg[2] == 16'h1007,
            "R6 chain order", log_msg[2], 16'h1007);
        chk(log_cy[2] - log_cy[1] == 3, "R5 zero delay", log_cy[2] - log_cy[1], 3);
        tick_once(); tick_once(); step(6);
        chk(busy === 1'b1, "R5 two of three ticks", busy, 1);
        tick_once(); step(6);
        chk(busy === 1'b0, "R3 next end stops", busy, 0);
        chk(seq_err === 1'b0, "R3 no error", seq_err, 0);
        tick_auto = 1;
    endtask

    task automatic t_backpressure();
        msg_ready = 1'b0; log_n = 0;
        pulse(4); step(8);
        chk(msg_valid === 1'b1 && msg_data == 16'hA000, "R4 offered", msg_data, 16'hA000);
        step(6);
        chk(msg_valid === 1'b1 && msg_data == 16'hA000, "R4 held", msg_data, 16'hA000);
        chk(log_n == 0, "R4 not taken", log_n, 0);
        msg_ready = 1'b1;
        step(60);
        chk(log_n == 1, "R4 taken once", log_n, 1);
    endtask

    task automatic t_err();
        wr(4'd5, 8'h50); log_n = 0;
        pulse(2); step(20);
        chk(seq_err === 1'b1, "R10 bad start", seq_err, 1);
        chk(busy === 1'b0 && log_n == 0, "R10 stopped", log_n, 0);
        load_ins(10, 16'h2010, 8'd0, 8'h80);
        wr(4'd5, 8'd10);
        pulse(2); step(30);
        chk(log_n == 1 && log_msg[0] == 16'h2010, "R10 bad next msg", log_msg[0], 16'h2010);
        chk(seq_err === 1'b1 && busy === 1'b0, "R10 bad next", seq_err, 1);
        pulse(4); step(10);
        chk(seq_err === 1'b0, "R10 clears on start", seq_err, 0);
        step(60);
        wr(4'd6, 8'h3f); log_n = 0;
        pulse(3); step(20);
        chk(log_n == 0 && seq_err === 1'b0, "R3 start at end", log_n, 0);
        wr(4'd0, 8'h00);
        wr(4'd6, 8'd5);
        pulse(3); step(20);
        chk(log_n == 0, "R2 relock", log_n, 0);
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_lock();
        t_prio();
        t_gate();
        t_chain();
        t_backpressure();
        t_err();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule